// File: doc/BRIEF.md
# Interrupt and TIC Time-Base Generator

This block is a free-running divider chain clocked by the system clock. It produces a periodic interrupt pulse and a slower TIC strobe. The TIC is made by counting wraps of the interrupt divider, so the interrupt period always divides the TIC period exactly. Every Nth interrupt pulse falls on the same clock as a TIC.

A single control word sets four things: the interrupt divisor, a choice between a long and a short TIC ratio, an interrupt enable that forces the output pin low while it is clear, and the source of a status-sample strobe. That source is either the internal interrupt pulse or rising edges of an external interrupt input after synchronisation. A write that changes the divisor or the ratio restarts both counters from zero. A write that changes only the enable or the source leaves the phase alone.

Top module: `tbase_gen`

## Requirements
- R1: After reset the divisor is 2886 clocks, the long ratio is selected, the interrupt enable is clear (pin held low), the sample source is internal, and all outputs are low. The first internal pulse, seen on `sample_strobe`, comes 2886 clocks after reset is released.
- R2: The internal interrupt pulse is one clock wide and repeats every D clocks, where D is the programmed divisor. The first pulse comes D clocks after the reset release or after the restarting write edge.
- R3: With `cfg_short_tic`=0 a TIC comes every 198 interrupt periods; with `cfg_short_tic`=1 it comes every 18. Each TIC is one clock wide and asserts in the same cycle as an interrupt pulse.
- R4: `irq_pin` equals the internal pulse while `cfg_irq_en`=1 is registered, and is low while it is 0.
- R5: A divisor below 2 is written as 2.
- R6: A write whose divisor or ratio select differs from the current setting restarts both counters. The next interrupt comes D clocks after the write edge, and the next TIC D×ratio clocks after it.
- R7: A write that changes only the enable or the source leaves the interrupt and TIC phase unchanged.
- R8: With `cfg_ext_src`=0, `sample_strobe` is the internal pulse and does not depend on the enable. With `cfg_ext_src`=1 it is a one-clock strobe two clocks after a rising edge of `ext_irq_in` is first sampled, and falling edges produce nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_div | input | 16 | Interrupt divisor in clocks |
| cfg_short_tic | input | 1 | 1 selects the short TIC ratio |
| cfg_irq_en | input | 1 | 1 lets the interrupt reach the pin |
| cfg_ext_src | input | 1 | 1 samples status on external input edges |
| ext_irq_in | input | 1 | Asynchronous external interrupt input |
| irq_pin | output | 1 | Gated interrupt output |
| tic_pulse | output | 1 | One-clock TIC strobe |
| sample_strobe | output | 1 | One-clock status-sample strobe |

## Verification
The assertions take for granted that reset is applied cleanly at start-up. They also assume that `cfg_we` is a single-cycle strobe and that `ext_irq_in`, although asynchronous, stays at each level for more clocks than the synchroniser depth. The stimulus changes inputs only on the falling clock edge and keeps `ext_irq_in` high for several clocks before lowering it. Writes are issued both on period boundaries and in mid-period, so restart and non-restart writes are exercised at points where the phase is observable.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
   typedef enum logic {
      TIC_LONG  = 1'b0,
      TIC_SHORT = 1'b1
   } tic_sel_e;

   typedef enum logic {
      SRC_INTERNAL = 1'b0,
      SRC_EXTERNAL = 1'b1
   } src_sel_e;
endpackage

// File: rtl/tbase_cfg.sv
module tbase_cfg
   import tbase_pkg::*;
#(
   parameter int DIV_W   = 16,
   parameter int DEF_DIV = 2886,
   parameter int MIN_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [DIV_W-1:0] div_in,
   input  logic             short_in,
   input  logic             en_in,
   input  logic             src_in,
   output logic [DIV_W-1:0] div_q,
   output tic_sel_e         tsel_q,
   output logic             en_q,
   output src_sel_e         src_q,
   output logic             restart
);
   localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);
   localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(DEF_DIV);

   logic [DIV_W-1:0] div_clamped;
   tic_sel_e         tsel_in;

   always_comb begin
      div_clamped = (div_in < FLOOR) ? FLOOR : div_in;
      tsel_in     = tic_sel_e'(short_in);
      restart     = we && ((div_clamped != div_q) || (tsel_in != tsel_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= RST_DIV;
         tsel_q <= TIC_LONG;
         en_q   <= 1'b0;
         src_q  <= SRC_INTERNAL;
      end else if (we) begin
         div_q  <= div_clamped;
         tsel_q <= tsel_in;
         en_q   <= en_in;
         src_q  <= src_sel_e'(src_in);
      end
   end
endmodule

// File: rtl/tbase_modcnt.sv
module tbase_modcnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] last,
   output logic         at_end
);
   logic [W-1:0] cnt;

   assign at_end = (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= at_end ? '0 : cnt + W'(1);
      end
   end
endmodule

// File: rtl/tbase_edge.sv
module tbase_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise
);
   logic [STAGES-1:0] sq;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq[0] <= 1'b0;
      else        sq[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sq[i] <= 1'b0;
         else        sq[i] <= sq[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= sq[STAGES-1];
   end

   assign rise = sq[STAGES-1] & ~prev;
endmodule

// File: rtl/tbase_gen.sv
module tbase_gen
   import tbase_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int DEF_DIV     = 2886,
   parameter int MIN_DIV     = 2,
   parameter int RATIO_LONG  = 198,
   parameter int RATIO_SHORT = 18,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_short_tic,
   input  logic             cfg_irq_en,
   input  logic             cfg_ext_src,
   input  logic             ext_irq_in,
   output logic             irq_pin,
   output logic             tic_pulse,
   output logic             sample_strobe
);
   localparam int RATIO_MAX = (RATIO_LONG > RATIO_SHORT) ? RATIO_LONG : RATIO_SHORT;
   localparam int RATIO_W   = $clog2(RATIO_MAX + 1);

   if (MIN_DIV < 2) begin : g_bad_min
      $error("MIN_DIV must be at least 2");
   end
   if (DEF_DIV < MIN_DIV || DEF_DIV >= (1 << DIV_W)) begin : g_bad_def
      $error("DEF_DIV out of range for DIV_W");
   end
   if (RATIO_LONG < 1 || RATIO_SHORT < 1) begin : g_bad_ratio
      $error("TIC ratios must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [DIV_W-1:0]   div_q;
   tic_sel_e           tsel_q;
   logic               en_q;
   src_sel_e           src_q;
   logic               restart;
   logic [DIV_W-1:0]   div_last;
   logic [RATIO_W-1:0] ratio;
   logic [RATIO_W-1:0] ratio_last;
   logic               int_end;
   logic               tic_end;
   logic               irq_q;
   logic               tic_q;
   logic               ext_rise;

   tbase_cfg #(
      .DIV_W   (DIV_W),
      .DEF_DIV (DEF_DIV),
      .MIN_DIV (MIN_DIV)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .div_in   (cfg_div),
      .short_in (cfg_short_tic),
      .en_in    (cfg_irq_en),
      .src_in   (cfg_ext_src),
      .div_q    (div_q),
      .tsel_q   (tsel_q),
      .en_q     (en_q),
      .src_q    (src_q),
      .restart  (restart)
   );

   always_comb begin
      div_last   = div_q - DIV_W'(1);
      ratio      = (tsel_q == TIC_SHORT) ? RATIO_W'(RATIO_SHORT) : RATIO_W'(RATIO_LONG);
      ratio_last = ratio - RATIO_W'(1);
   end

   tbase_modcnt #(.W(DIV_W)) u_icnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (restart),
      .step   (1'b1),
      .last   (div_last),
      .at_end (int_end)
   );

   tbase_modcnt #(.W(RATIO_W)) u_tcnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (restart),
      .step   (int_end),
      .last   (ratio_last),
      .at_end (tic_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         tic_q <= 1'b0;
      end else begin
         irq_q <= int_end & ~restart;
         tic_q <= int_end & tic_end & ~restart;
      end
   end

   tbase_edge #(.STAGES(SYNC_STAGES)) u_ext (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_irq_in),
      .rise  (ext_rise)
   );

   assign irq_pin       = irq_q & en_q;
   assign tic_pulse     = tic_q;
   assign sample_strobe = (src_q == SRC_EXTERNAL) ? ext_rise : irq_q;
endmodule

// File: rtl/tbase_gen_chk.sv
module tbase_gen_chk #(
   parameter int DIV_W   = 16,
   parameter int RATIO_W = 8,
   parameter int MIN_DIV = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               restart,
   input logic [DIV_W-1:0]   eff_div,
   input logic [RATIO_W-1:0] ratio,
   input logic               irq_en,
   input logic               ext_src,
   input logic               irq_q,
   input logic               irq_pin,
   input logic               tic_pulse,
   input logic               sample_strobe
);
   logic [DIV_W:0]   gap;
   logic [RATIO_W-1:0] tcount;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap    <= '0;
         tcount <= '0;
      end else begin
         if (restart)          gap <= '0;
         else if (irq_q)       gap <= (DIV_W+1)'(1);
         else if (~&gap)       gap <= gap + (DIV_W+1)'(1);
         if (restart)          tcount <= '0;
         else if (irq_q)       tcount <= tic_pulse ? '0 : tcount + RATIO_W'(1);
      end
   end

   AST_IRQ_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (gap == {1'b0, eff_div}) |-> irq_q);                               // R2
   AST_IRQ_ONLY_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (gap == {1'b0, eff_div}));                               // R2
   AST_IRQ_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);                                                 // R2
   AST_TIC_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      tic_pulse |-> (irq_q && tcount == ratio - RATIO_W'(1)));           // R3
   AST_TIC_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && tcount == ratio - RATIO_W'(1)) |-> tic_pulse);           // R3
   AST_PIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq_pin);                                             // R4
   AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      eff_div >= DIV_W'(MIN_DIV));                                       // R5
   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!irq_q && !tic_pulse));                               // R6
   AST_EXT_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_src && sample_strobe) |=> (!sample_strobe || !ext_src));      // R8
endmodule

bind tbase_gen tbase_gen_chk #(
   .DIV_W   (DIV_W),
   .RATIO_W (RATIO_W),
   .MIN_DIV (MIN_DIV)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .restart       (restart),
   .eff_div       (div_q),
   .ratio         (ratio),
   .irq_en        (en_q),
   .ext_src       (src_q == tbase_pkg::SRC_EXTERNAL),
   .irq_q         (irq_q),
   .irq_pin       (irq_pin),
   .tic_pulse     (tic_pulse),
   .sample_strobe (sample_strobe)
);

// File: tb/tbase_gen_test.sv
`timescale 1ns/1ps
module tbase_gen_test;
   localparam int LONG_R  = 198;
   localparam int SHORT_R = 18;
   localparam int NVEC    = 6;
   // columns: written divisor, short select, effective divisor
   localparam int VECS [NVEC][3] = '{
      '{7, 1, 7}, '{10, 1, 10}, '{5, 0, 5}, '{1, 1, 2}, '{3, 0, 3}, '{2, 0, 2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_div = '0;
   logic        cfg_short_tic = 1'b0;
   logic        cfg_irq_en = 1'b0;
   logic        cfg_ext_src = 1'b0;
   logic        ext_irq_in = 1'b0;
   logic        irq_pin, tic_pulse, sample_strobe;

   int nchk = 0;
   int nerr = 0;
   int ec   = 0;

   always #2.5 clk = ~clk;

   tbase_gen uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_div       (cfg_div),
      .cfg_short_tic (cfg_short_tic),
      .cfg_irq_en    (cfg_irq_en),
      .cfg_ext_src   (cfg_ext_src),
      .ext_irq_in    (ext_irq_in),
      .irq_pin       (irq_pin),
      .tic_pulse     (tic_pulse),
      .sample_strobe (sample_strobe)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      ec++;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic write_cfg(input int div, input bit sh, input bit en, input bit src);
      cfg_div       = 16'(div);
      cfg_short_tic = sh;
      cfg_irq_en    = en;
      cfg_ext_src   = src;
      cfg_we        = 1'b1;
      tick();
      cfg_we        = 1'b0;
   endtask

   // scans one full TIC period after a restarting write at edge w
   task automatic scan(input int d, input int r, input int w, input string req);
      int bad_irq = 0, bad_tic = 0, first_irq = -1, first_tic = -1;
      while (ec < w + d * r) begin
         tick();
         begin
            int n = ec - w;
            bit e_irq = (n % d == 0);
            bit e_tic = (n == d * r);
            if (irq_pin !== e_irq || sample_strobe !== e_irq) begin
               bad_irq++;
               if (first_irq < 0) first_irq = n;
            end
            if (tic_pulse !== e_tic) begin
               bad_tic++;
               if (first_tic < 0) first_tic = n;
            end
         end
      end
      check(bad_irq == 0, req, "interrupt cadence mismatches (first at clock)", first_irq, -1);
      check(bad_tic == 0, "R3", "TIC cadence mismatches (first at clock)", first_tic, -1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired actual %0d expected %0d", ec, 0);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      int w0, w;
      int pin_bad, strobe_bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      ec = 0;

      // R1: outputs low out of reset
      check({irq_pin, tic_pulse, sample_strobe} == 3'b000, "R1", "outputs after reset",
            {irq_pin, tic_pulse, sample_strobe}, 0);

      // R1: default divisor visible on the internal strobe, pin masked
      pin_bad = 0; strobe_bad = 0;
      while (ec < 2886) begin
         tick();
         if (irq_pin !== 1'b0) pin_bad++;
         if (sample_strobe !== (ec == 2886)) strobe_bad++;
      end
      check(pin_bad == 0, "R1", "pin pulses while masked by reset", pin_bad, 0);
      check(strobe_bad == 0, "R1", "default-period strobe mismatches", strobe_bad, 0);

      // R2 R3 R5 R6: vector table, each write restarts the chain
      for (int i = 0; i < NVEC; i++) begin
         write_cfg(VECS[i][0], VECS[i][1] != 0, 1'b1, 1'b0);
         w = ec;
         scan(VECS[i][2], (VECS[i][1] != 0) ? SHORT_R : LONG_R, w,
              (VECS[i][0] < 2) ? "R5" : "R2");
      end

      // R4 R7 R8: mask-only writes keep phase, strobe ignores the mask
      write_cfg(10, 1'b1, 1'b1, 1'b0);
      w0 = ec;
      repeat (3) tick();
      write_cfg(10, 1'b1, 1'b0, 1'b0);
      pin_bad = 0; strobe_bad = 0;
      while (ec < w0 + 20) begin
         tick();
         if (irq_pin !== 1'b0) pin_bad++;
         if (sample_strobe !== ((ec - w0) % 10 == 0)) strobe_bad++;
      end
      check(pin_bad == 0, "R4", "pin pulses while disabled", pin_bad, 0);
      check(strobe_bad == 0, "R8", "internal strobe mismatches while disabled", strobe_bad, 0);
      write_cfg(10, 1'b1, 1'b1, 1'b0);
      pin_bad = 0;
      while (ec < w0 + 30) begin
         tick();
         if (irq_pin !== (ec == w0 + 30)) pin_bad++;
      end
      check(pin_bad == 0, "R7", "phase after enable-only write", pin_bad, 0);

      // R8: external source, rising edge gives one strobe two clocks later
      write_cfg(10, 1'b1, 1'b1, 1'b1);
      ext_irq_in = 1'b1;
      tick();
      check(sample_strobe == 1'b0, "R8", "strobe one clock after ext rise", sample_strobe, 0);
      tick();
      check(sample_strobe == 1'b1, "R8", "strobe two clocks after ext rise", sample_strobe, 1);
      tick();
      check(sample_strobe == 1'b0, "R8", "strobe width", sample_strobe, 0);
      while (ec < w0 + 40) tick();
      check(irq_pin == 1'b1, "R7", "pin phase after source-only write", irq_pin, 1);
      check(sample_strobe == 1'b0, "R8", "internal pulse leaking to external strobe",
            sample_strobe, 0);
      ext_irq_in = 1'b0;
      strobe_bad = 0;
      repeat (4) begin
         tick();
         if (sample_strobe !== 1'b0) strobe_bad++;
      end
      check(strobe_bad == 0, "R8", "strobes on falling ext edge", strobe_bad, 0);

      // R6: mid-period divisor change restarts from the write edge
      write_cfg(13, 1'b1, 1'b1, 1'b0);
      w = ec;
      scan(13, SHORT_R, w, "R6");

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule